// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from thirty-one peripheral sources, numbered 1 to 31, and drives a single active-low request line toward a processor. Each source is given its own mode: a three-bit priority (7 is most urgent, 0 least), a choice between edge and level detection, and an enable bit. A processor handles an interrupt in three steps. It sees the request line go low. It performs an acknowledge read, which returns the number of the source to service. It signals the end of service with a completion write.

The winner is chosen at the moment of the acknowledge, not when the line first goes low. A source that became pending in the meantime can therefore overtake the one that raised the line. Each acknowledge pushes the winner's priority onto a small hardware stack. While the stack is not empty, only a source whose priority is strictly above the top entry can raise the line. A completion write pops the stack, and requests that were held back become eligible again.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_n` is 1, `vec_o` is 0, the nesting stack is empty and every source is disabled.
- R2: The controller latches a rising edge on an enabled edge-mode source. `irq_n` is 1 at the second clock edge after the input is first sampled high and 0 from the third. The latched request survives the input falling again.
- R3: An enabled level-mode source drives `irq_n` low from the second clock edge after its input is sampled high. It stops requesting as soon as its input falls, and a later acknowledge then returns 0.
- R4: A source whose enable bit is 0 never lowers `irq_n` and is never returned by an acknowledge.
- R5: Arbitration happens in the cycle of `ack_rd`. A higher-priority source that became pending after `irq_n` fell wins over the source that lowered it.
- R6: Among eligible sources, the acknowledge returns the one with the numerically greatest priority.
- R7: When eligible sources share the greatest priority, the acknowledge returns the lowest source number.
- R8: `vec_o` shows the acknowledged source number from the clock edge that samples `ack_rd`. The acknowledge clears that source's latched edge request, so it does not fire again until a new rising edge.
- R9: While the stack is not empty, only a pending source with priority strictly greater than the top-of-stack priority lowers `irq_n`. An equal or lower one waits.
- R10: `eoi_wr` pops one stack entry, which restores the previous threshold. Held requests that now clear it lower `irq_n` again.
- R11: An acknowledge with no eligible source returns 0 and leaves the stack unchanged.
- R12: `eoi_wr` is ignored when the stack is empty, and also in a cycle in which `ack_rd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 31 | Request inputs, bit n is source n (bits 31:1) |
| cfg_we | input | 1 | Writes the mode of source `cfg_sel` |
| cfg_sel | input | 5 | Source number to configure (0 ignored) |
| cfg_prio | input | 3 | Priority to store, 7 highest |
| cfg_edge | input | 1 | 1 selects edge detection, 0 level |
| cfg_en | input | 1 | Source enable |
| ack_rd | input | 1 | Acknowledge read strobe |
| eoi_wr | input | 1 | End-of-service write strobe |
| vec_o | output | 5 | Source number returned by the last acknowledge, 0 if spurious |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest situation to reach from the ports is a held-back request that must come back after a completion write. To get there, the stack has to be two levels deep and a request must have arrived while it was blocked by an equal priority. The bench builds this on purpose. It acknowledges a level source, raises an equal-priority edge source and a higher one, and acknowledges the higher one. It then pops the stack one level at a time. After the first pop the line must stay high, and after the second it must fall. Another sequence pairs an acknowledge and a completion write in the same cycle while nothing is eligible, and then shows that the stack was left untouched.

// File: rtl/nic_pkg.sv
// Package nic_pkg
// Shared sizes and types for the nested interrupt controller.
// Assumes sources are numbered from 1; number 0 is the spurious code.
package nic_pkg;
    localparam int NIC_NSRC   = 31;
    localparam int NIC_PRIO_W = 3;
    localparam int NIC_IDX_W  = $clog2(NIC_NSRC + 1);
    localparam int NIC_NLVL   = 1 << NIC_PRIO_W;

    typedef logic [NIC_PRIO_W-1:0] nic_prio_t;
    typedef logic [NIC_IDX_W-1:0]  nic_idx_t;
endpackage

// File: rtl/nic_src_bank.sv
// Module nic_src_bank
// Holds the per-source mode (priority, edge/level, enable), samples the
// raw inputs once, latches rising edges for edge-mode sources and outputs
// the enabled pending vector. Assumes clr_idx names a valid source when
// clr_en is high.
module nic_src_bank #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC:1]               src_i,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_sel,
    input  logic [PRIO_W-1:0]           cfg_prio,
    input  logic                        cfg_edge,
    input  logic                        cfg_en,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_idx,
    output logic [NSRC:1]               pend_o,
    output logic [NSRC:1][PRIO_W-1:0]   prio_o
);
    logic [NSRC:1] smp_q;
    logic [NSRC:1] smp_d;
    logic [NSRC:1] edge_q;
    logic [NSRC:1] en_q;
    logic [NSRC:1] lvl_mode;
    logic [NSRC:1] rise;

    // Sample the raw inputs and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
            smp_d <= '0;
        end else begin
            smp_q <= src_i;
            smp_d <= smp_q;
        end
    end

    assign rise = smp_q & ~smp_d;

    for (genvar i = 1; i <= NSRC; i++) begin : g_src
        // Store the mode fields of source i when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_o[i]   <= '0;
                lvl_mode[i] <= 1'b1;
                en_q[i]     <= 1'b0;
            end else if (cfg_we && (cfg_sel == IDX_W'(i))) begin
                prio_o[i]   <= cfg_prio;
                lvl_mode[i] <= ~cfg_edge;
                en_q[i]     <= cfg_en;
            end
        end

        // Latch a rising edge; a new edge wins over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                edge_q[i] <= 1'b0;
            else if (lvl_mode[i])
                edge_q[i] <= 1'b0;
            else if (rise[i])
                edge_q[i] <= 1'b1;
            else if (clr_en && (clr_idx == IDX_W'(i)))
                edge_q[i] <= 1'b0;
        end

        // Merge both detection styles and apply the enable mask.
        assign pend_o[i] = en_q[i] & (lvl_mode[i] ? smp_q[i] : edge_q[i]);
    end

    // R8
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_idx != '0 && !lvl_mode[clr_idx] && !rise[clr_idx])
        |=> !edge_q[$past(clr_idx)]);

    // R4
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~en_q) == '0));
endmodule

// File: rtl/nic_arbiter.sv
// Module nic_arbiter
// Combinational selection among pending sources above the nesting
// threshold: greatest priority wins, ties go to the lowest number.
// Returns index 0 and valid low when no source qualifies.
module nic_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 5
) (
    input  logic [NSRC:1]             req_i,
    input  logic [NSRC:1][PRIO_W-1:0] prio_i,
    input  logic                      thr_en,
    input  logic [PRIO_W-1:0]         thr_prio,
    output logic                      win_valid,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    // Scan from the highest number down so ">=" lets lower numbers win ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = NSRC; i >= 1; i--) begin
            if (req_i[i] && (!thr_en || prio_i[i] > thr_prio) &&
                (!win_valid || prio_i[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/nic_lvl_stack.sv
// Module nic_lvl_stack
// Shift-register stack of active priority levels; entry 0 is the top.
// Assumes pushes only carry a priority above the current top, so at most
// one entry per level can be held.
module nic_lvl_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    output logic              empty_o,
    output logic [PRIO_W-1:0] top_prio_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][PRIO_W-1:0] ent_q;
    logic [CW-1:0]                cnt_q;

    // Track occupancy; push has precedence over pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push)
            cnt_q <= cnt_q + 1'b1;
        else if (pop && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        // Shift entries down on push, up on pop.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[k] <= '0;
            else if (push)
                ent_q[k] <= (k == 0) ? push_prio : ent_q[(k == 0) ? 0 : k-1];
            else if (pop && cnt_q != '0)
                ent_q[k] <= (k == DEPTH-1) ? '0 : ent_q[(k == DEPTH-1) ? k : k+1];
        end
    end

    assign empty_o    = (cnt_q == '0);
    assign top_prio_o = ent_q[0];

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CW'(DEPTH)));

    // R9
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt_q != '0) |-> (push_prio > ent_q[0]));

    // R12
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/nest_irq_ctrl.sv
// Module nest_irq_ctrl
// Top of the nested priority interrupt controller. Registers the request
// line from the arbiter, performs acknowledge (push + vector capture) and
// end-of-service (pop). Assumes one strobe per cycle from software; a
// completion write coinciding with an acknowledge is dropped.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NSRC   = NIC_NSRC,
    parameter int PRIO_W = NIC_PRIO_W,
    parameter int IDX_W  = $clog2(NSRC + 1),
    parameter int NLVL   = 1 << PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     src_i,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              cfg_edge,
    input  logic              cfg_en,
    input  logic              ack_rd,
    input  logic              eoi_wr,
    output logic [IDX_W-1:0]  vec_o,
    output logic              irq_n
);
    logic [NSRC:1]             pend;
    logic [NSRC:1][PRIO_W-1:0] prio;
    logic                      win_valid;
    logic [IDX_W-1:0]          win_idx;
    logic [PRIO_W-1:0]         win_prio;
    logic                      stk_empty;
    logic [PRIO_W-1:0]         stk_top;
    logic                      take;
    logic                      pop;

    assign take = ack_rd & win_valid;
    assign pop  = eoi_wr & ~ack_rd;

    nic_src_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_prio(cfg_prio),
        .cfg_edge(cfg_edge), .cfg_en(cfg_en),
        .clr_en(take), .clr_idx(win_idx),
        .pend_o(pend), .prio_o(prio)
    );

    nic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) arb_i (
        .req_i(pend), .prio_i(prio),
        .thr_en(~stk_empty), .thr_prio(stk_top),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
    );

    nic_lvl_stack #(.DEPTH(NLVL), .PRIO_W(PRIO_W)) stk_i (
        .clk(clk), .rst_n(rst_n),
        .push(take), .pop(pop), .push_prio(win_prio),
        .empty_o(stk_empty), .top_prio_o(stk_top)
    );

    // Register the request line and the vector captured on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
            vec_o <= '0;
        end else begin
            irq_n <= ~win_valid;
            if (ack_rd)
                vec_o <= win_valid ? win_idx : '0;
        end
    end

    // R6
    win_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> pend[win_idx]);

    // R9
    win_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !stk_empty) |-> (win_prio > stk_top));

    // R11
    spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !win_valid) |=> (vec_o == '0));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:1] src_i = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [2:0]  cfg_prio = '0;
    logic        cfg_edge = 1'b0;
    logic        cfg_en = 1'b0;
    logic        ack_rd = 1'b0;
    logic        eoi_wr = 1'b0;
    logic [4:0]  vec_o;
    logic        irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_prio(cfg_prio),
        .cfg_edge(cfg_edge), .cfg_en(cfg_en),
        .ack_rd(ack_rd), .eoi_wr(eoi_wr), .vec_o(vec_o), .irq_n(irq_n)
    );

    // Vector table: {source[8:4], priority[3:1], edge[0]}
    localparam logic [8:0] TBL [6] = '{
        {5'd1,  3'd0, 1'b1}, {5'd31, 3'd7, 1'b0}, {5'd12, 3'd3, 1'b1},
        {5'd17, 3'd5, 1'b0}, {5'd8,  3'd1, 1'b0}, {5'd26, 3'd6, 1'b1}
    };

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; src_i = '0; ack_rd = 1'b0; eoi_wr = 1'b0; cfg_we = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic cfg(input int idx, input int pr, input bit edg, input bit en);
        cfg_we = 1'b1; cfg_sel = 5'(idx); cfg_prio = 3'(pr); cfg_edge = edg; cfg_en = en;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        ack_rd = 1'b1; cyc(1); ack_rd = 1'b0;
    endtask

    task automatic eoi();
        eoi_wr = 1'b1; cyc(1); eoi_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(1);
        do_reset();
        check("R1 irq_n after reset", irq_n, 1);
        check("R1 vec_o after reset", vec_o, 0);
        src_i[7] = 1'b1;
        cyc(3);
        check("R1 sources disabled after reset", irq_n, 1);

        // Table walk: latency, vector, clear on acknowledge
        for (int t = 0; t < 6; t++) begin
            int idx = int'(TBL[t][8:4]);
            int pr  = int'(TBL[t][3:1]);
            bit edg = TBL[t][0];
            int lat = edg ? 3 : 2;
            do_reset();
            cfg(idx, pr, edg, 1'b1);
            src_i[idx] = 1'b1;
            cyc(lat - 1);
            check(edg ? "R2 edge not yet" : "R3 level not yet", irq_n, 1);
            cyc(1);
            check(edg ? "R2 edge latency" : "R3 level latency", irq_n, 0);
            if (edg) begin
                src_i[idx] = 1'b0;
                cyc(2);
                check("R2 edge held after input fall", irq_n, 0);
            end
            ack();
            check("R8 vector", vec_o, idx);
            src_i[idx] = 1'b0;
            eoi();
            cyc(2);
            check("R8 no refire after acknowledge", irq_n, 1);
        end

        // R4 disabled source
        do_reset();
        cfg(14, 3, 1'b1, 1'b0);
        src_i[14] = 1'b1;
        cyc(4);
        check("R4 disabled no irq", irq_n, 1);
        ack();
        check("R4 disabled not returned", vec_o, 0);

        // R5 deferred arbitration
        do_reset();
        cfg(5, 1, 1'b1, 1'b1);
        cfg(6, 4, 1'b1, 1'b1);
        src_i[5] = 1'b1;
        cyc(3);
        check("R5 first request", irq_n, 0);
        src_i[6] = 1'b1;
        cyc(2);
        ack();
        check("R5 late higher source wins", vec_o, 6);

        // R6 priority order
        do_reset();
        cfg(4, 1, 1'b0, 1'b1);
        cfg(9, 6, 1'b0, 1'b1);
        src_i[4] = 1'b1; src_i[9] = 1'b1;
        cyc(2);
        ack();
        check("R6 greatest priority wins", vec_o, 9);

        // R7 tie break, edge sources
        do_reset();
        cfg(3, 5, 1'b1, 1'b1);
        cfg(7, 5, 1'b1, 1'b1);
        src_i[3] = 1'b1; src_i[7] = 1'b1;
        cyc(3);
        ack();
        check("R7 lowest number on tie", vec_o, 3);
        eoi();
        cyc(1);
        ack();
        check("R7 second of tie", vec_o, 7);

        // R9/R10 nesting
        do_reset();
        cfg(10, 2, 1'b0, 1'b1);
        cfg(20, 2, 1'b1, 1'b1);
        cfg(25, 6, 1'b1, 1'b1);
        src_i[10] = 1'b1;
        cyc(2);
        ack();
        check("R9 first level", vec_o, 10);
        src_i[20] = 1'b1;
        cyc(4);
        check("R9 equal priority held", irq_n, 1);
        src_i[25] = 1'b1;
        cyc(3);
        check("R9 higher preempts", irq_n, 0);
        ack();
        check("R9 nested vector", vec_o, 25);
        cyc(2);
        eoi();
        cyc(2);
        check("R10 one pop still blocks equal", irq_n, 1);
        eoi();
        cyc(2);
        check("R10 held request released", irq_n, 0);
        ack();
        check("R7 tie after release", vec_o, 10);

        // R3 level drop
        do_reset();
        cfg(21, 2, 1'b0, 1'b1);
        src_i[21] = 1'b1;
        cyc(2);
        check("R3 level asserted", irq_n, 0);
        src_i[21] = 1'b0;
        cyc(2);
        check("R3 level drop releases", irq_n, 1);
        ack();
        check("R3 acknowledge after drop", vec_o, 0);

        // R11 spurious does not push
        do_reset();
        ack();
        check("R11 spurious code", vec_o, 0);
        cfg(2, 0, 1'b0, 1'b1);
        src_i[2] = 1'b1;
        cyc(2);
        check("R11 stack still empty", irq_n, 0);

        // R12 ignored completion writes
        do_reset();
        eoi();
        cfg(3, 4, 1'b0, 1'b1);
        cfg(11, 4, 1'b1, 1'b1);
        src_i[3] = 1'b1;
        cyc(2);
        check("R12 empty pop ignored", irq_n, 0);
        ack();
        check("R12 vector", vec_o, 3);
        src_i[11] = 1'b1;
        cyc(4);
        check("R12 blocked equal", irq_n, 1);
        ack_rd = 1'b1; eoi_wr = 1'b1;
        cyc(1);
        ack_rd = 1'b0; eoi_wr = 1'b0;
        check("R12 same-cycle spurious", vec_o, 0);
        cyc(2);
        check("R12 pop with acknowledge ignored", irq_n, 1);
        eoi();
        cyc(2);
        check("R12 real pop releases", irq_n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule